// File: doc/BRIEF.md
# Hashed Page Table Group Index Generator

This block turns a virtual page number into the two places a hardware table walker may look for its translation: the primary group and the secondary group of a hashed page table. The page number is split into a segment part and a page part; where the split falls depends on whether the access is to a large page or a small page. The two parts are combined by exclusive-or into a raw hash. The primary group index is the raw hash ANDed with a programmable hash mask. The secondary group index is the bitwise complement of the raw hash, ANDed with the same mask.

Each group holds eight 16-byte entries, so a group occupies 128 bytes. The block reports each index together with its byte offset from the start of the table. Requests arrive on a valid/ready handshake. The result is registered and appears one cycle after the request is accepted. It then stays on the outputs until the consumer takes it. The hash mask is loaded through a write strobe, and the load is accepted only while the block is idle.

Top module: `hpt_group_index`

## Requirements
- R1: For a small page (`reqLarge`=0), the segment part is `reqVpn >> 16` and the page part is `reqVpn[15:0]`. The raw hash is the low 39 bits of the segment part XORed with the page part, and `priIdx` is the raw hash's low `IDX_W` bits ANDed with the hash mask.
- R2: For a large page (`reqLarge`=1), the segment part is `reqVpn >> 4` and the page part is `reqVpn[3:0]`. The raw hash is formed as in R1.
- R3: `secIdx` equals the bitwise complement of the raw hash's low `IDX_W` bits, ANDed with the hash mask. It therefore shares no set bit with `priIdx`.
- R4: `priOffset` and `secOffset` equal the matching index shifted left by 7 (8 entries of 16 bytes per group).
- R5: A request is accepted on a clock edge where `reqValid` and `reqReady` are both 1. `rspValid` is 1 with the result in the cycle that follows. `rspValid` drops in the cycle after the edge where `rspValid` and `rspReady` are both 1.
- R6: While `rspValid` is 1, `reqReady` is 0. All four result outputs hold their values until the result is taken.
- R7: A pulse on `maskWrEn` loads `maskWrData` as the hash mask when no result is pending and no request is accepted on the same edge. Otherwise the write is ignored and the old mask stays in use. A request uses the mask in effect at its acceptance edge.
- R8: After reset, `rspValid` is 0, `reqReady` is 1, all result outputs are 0 and the hash mask is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Block can take a request |
| reqVpn | input | VPN_W | Virtual page number |
| reqLarge | input | 1 | 1 selects the large-page split |
| maskWrEn | input | 1 | Hash mask write strobe |
| maskWrData | input | IDX_W | New hash mask value |
| rspValid | output | 1 | Result available |
| rspReady | input | 1 | Consumer takes the result |
| priIdx | output | IDX_W | Primary group index |
| secIdx | output | IDX_W | Secondary group index |
| priOffset | output | IDX_W+7 | Byte offset of the primary group |
| secOffset | output | IDX_W+7 | Byte offset of the secondary group |

## Verification
Results are due one cycle after the acceptance edge. The bench drives inputs on falling edges and reads the outputs at the first falling edge after acceptance. It then holds `rspReady` low for a few cycles and reads again, to confirm that the result stays stable and that `reqReady` stays low. After the edge where the result is taken, it expects `rspValid` to be 0 at the next falling edge. Mask writes are checked one request later: the index of the next accepted request shows which mask was in effect, covering writes made while idle, while a result is pending, and on the acceptance edge.

// File: rtl/hpt_group_index_pkg.sv
package hpt_group_index_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic capture;   // latch a new result this edge
    logic maskLoad;  // load the hash mask this edge
  } hpt_strobe_t;
endpackage

// File: rtl/hpt_group_index_ctrl.sv
module hpt_group_index_ctrl
  import hpt_group_index_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        rspReady,
  input  logic        maskWrEn,
  output logic        reqReady,
  output logic        rspValid,
  output hpt_strobe_t strobes
);
  logic pending;

  assign reqReady = !pending;
  assign rspValid = pending;

  always_comb begin
    strobes.capture  = reqValid && !pending;
    // mask only changes with nothing in flight and nothing arriving
    strobes.maskLoad = maskWrEn && !pending && !(reqValid && !pending);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 pending <= 1'b0;
    else if (strobes.capture)  pending <= 1'b1;
    else if (rspReady)         pending <= 1'b0;
  end
endmodule

// File: rtl/hpt_group_index_dp.sv
module hpt_group_index_dp
  import hpt_group_index_pkg::*;
#(
  parameter int VPN_W       = 64,
  parameter int IDX_W       = 24,
  parameter int SMALL_SHIFT = 16,
  parameter int LARGE_SHIFT = 4,
  parameter int RAW_W       = 39,
  parameter int GROUP_SHIFT = 7
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  hpt_strobe_t              strobes,
  input  logic [VPN_W-1:0]         reqVpn,
  input  logic                     reqLarge,
  input  logic [IDX_W-1:0]         maskWrData,
  output logic [IDX_W-1:0]         priIdx,
  output logic [IDX_W-1:0]         secIdx,
  output logic [IDX_W+GROUP_SHIFT-1:0] priOffset,
  output logic [IDX_W+GROUP_SHIFT-1:0] secOffset
);
  localparam logic [VPN_W-1:0] SMALL_PG_MASK = (VPN_W'(1) << SMALL_SHIFT) - VPN_W'(1);
  localparam logic [VPN_W-1:0] LARGE_PG_MASK = (VPN_W'(1) << LARGE_SHIFT) - VPN_W'(1);

  logic [IDX_W-1:0] maskReg;
  logic [IDX_W-1:0] priReg, secReg;
  logic [VPN_W-1:0] segPart, pagePart;
  logic [RAW_W-1:0] rawHash;
  logic [IDX_W-1:0] rawLow;

  always_comb begin
    if (reqLarge) begin
      segPart  = reqVpn >> LARGE_SHIFT;
      pagePart = reqVpn & LARGE_PG_MASK;
    end else begin
      segPart  = reqVpn >> SMALL_SHIFT;
      pagePart = reqVpn & SMALL_PG_MASK;
    end
    rawHash = RAW_W'(segPart) ^ RAW_W'(pagePart);
    rawLow  = rawHash[IDX_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskReg <= '1;
      priReg  <= '0;
      secReg  <= '0;
    end else begin
      if (strobes.maskLoad) maskReg <= maskWrData;
      if (strobes.capture) begin
        priReg <= rawLow & maskReg;
        secReg <= ~rawLow & maskReg;
      end
    end
  end

  assign priIdx    = priReg;
  assign secIdx    = secReg;
  assign priOffset = {priReg, {GROUP_SHIFT{1'b0}}};
  assign secOffset = {secReg, {GROUP_SHIFT{1'b0}}};
endmodule

// File: rtl/hpt_group_index.sv
module hpt_group_index
  import hpt_group_index_pkg::*;
#(
  parameter int VPN_W = 64,
  parameter int IDX_W = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [VPN_W-1:0] reqVpn,
  input  logic             reqLarge,
  input  logic             maskWrEn,
  input  logic [IDX_W-1:0] maskWrData,
  output logic             rspValid,
  input  logic             rspReady,
  output logic [IDX_W-1:0] priIdx,
  output logic [IDX_W-1:0] secIdx,
  output logic [IDX_W+6:0] priOffset,
  output logic [IDX_W+6:0] secOffset
);
  localparam int ENTRY_LOG2  = 4;  // 16-byte entries
  localparam int SLOTS_LOG2  = 3;  // 8 entries per group
  localparam int GROUP_SHIFT = ENTRY_LOG2 + SLOTS_LOG2;

  hpt_strobe_t strobes;

  hpt_group_index_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .rspReady(rspReady),
    .maskWrEn(maskWrEn), .reqReady(reqReady), .rspValid(rspValid),
    .strobes(strobes)
  );

  hpt_group_index_dp #(
    .VPN_W(VPN_W), .IDX_W(IDX_W), .SMALL_SHIFT(16), .LARGE_SHIFT(4),
    .RAW_W(39), .GROUP_SHIFT(GROUP_SHIFT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .reqVpn(reqVpn),
    .reqLarge(reqLarge), .maskWrData(maskWrData), .priIdx(priIdx),
    .secIdx(secIdx), .priOffset(priOffset), .secOffset(secOffset)
  );
endmodule

// File: rtl/hpt_group_index_checker.sv
module hpt_group_index_checker #(
  parameter int IDX_W = 24
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic             reqReady,
  input logic             rspValid,
  input logic             rspReady,
  input logic [IDX_W-1:0] priIdx,
  input logic [IDX_W-1:0] secIdx,
  input logic [IDX_W+6:0] priOffset,
  input logic [IDX_W+6:0] secOffset
);
  p_accept_latency_r5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> rspValid);

  p_release_r5: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspReady) |=> !rspValid);

  p_no_accept_busy_r6: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> !reqReady);

  p_hold_result_r6: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspReady) |=> (rspValid && $stable(priIdx) && $stable(secIdx)
                                 && $stable(priOffset) && $stable(secOffset)));

  p_disjoint_idx_r3: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> ((priIdx & secIdx) == '0));

  p_offset_shift_r4: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (priOffset == {priIdx, 7'b0} && secOffset == {secIdx, 7'b0}));
endmodule

bind hpt_group_index hpt_group_index_checker #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .rspValid(rspValid), .rspReady(rspReady), .priIdx(priIdx), .secIdx(secIdx),
  .priOffset(priOffset), .secOffset(secOffset)
);

// File: tb/tb_hpt_group_index.sv
module tb_hpt_group_index;
  localparam int CLK_PERIOD = 10;
  localparam int VW = 24;
  localparam int IW = 10;

  logic          clk = 0;
  logic          rstN = 0;
  logic          reqValid = 0, reqLarge = 0, maskWrEn = 0, rspReady = 0;
  logic [VW-1:0] reqVpn = '0;
  logic [IW-1:0] maskWrData = '0;
  logic          reqReady, rspValid;
  logic [IW-1:0] priIdx, secIdx;
  logic [IW+6:0] priOffset, secOffset;

  int checks = 0;
  int fails = 0;
  logic [IW-1:0] curMask;

  always #(CLK_PERIOD/2) clk = ~clk;

  hpt_group_index #(.VPN_W(VW), .IDX_W(IW)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqVpn(reqVpn), .reqLarge(reqLarge), .maskWrEn(maskWrEn),
    .maskWrData(maskWrData), .rspValid(rspValid), .rspReady(rspReady),
    .priIdx(priIdx), .secIdx(secIdx), .priOffset(priOffset), .secOffset(secOffset)
  );

  function automatic logic [IW-1:0] rawLow(input logic [VW-1:0] v, input logic lg);
    longint unsigned seg, pg, raw;
    if (lg) begin seg = 64'(v) >> 4;  pg = 64'(v) & 64'hF; end
    else    begin seg = 64'(v) >> 16; pg = 64'(v) & 64'hFFFF; end
    raw = (seg & 64'h7F_FFFF_FFFF) ^ pg;
    return raw[IW-1:0];
  endfunction

  task automatic check(input string req, input longint unsigned act, input longint unsigned exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one transaction; hold = cycles the consumer stalls before taking it
  task automatic doReq(input logic [VW-1:0] v, input logic lg, input int hold,
                       input logic [IW-1:0] m);
    logic [IW-1:0] ep, es;
    ep = rawLow(v, lg) & m;
    es = ~rawLow(v, lg) & m;
    @(negedge clk);
    reqVpn = v; reqLarge = lg; reqValid = 1;
    @(negedge clk);
    reqValid = 0;
    check("R5 rspValid after accept", rspValid, 1);
    check(lg ? "R2 priIdx large" : "R1 priIdx small", priIdx, ep);
    check("R3 secIdx", secIdx, es);
    check("R4 offsets", {priOffset, secOffset}, {ep, 7'b0, es, 7'b0});
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      check("R6 held", {rspValid, reqReady, priIdx, secIdx}, {1'b1, 1'b0, ep, es});
    end
    rspReady = 1;
    @(negedge clk);
    rspReady = 0;
    check("R5 release", {rspValid, reqReady}, 2'b01);
  endtask

  task automatic writeMask(input logic [IW-1:0] m);
    @(negedge clk);
    maskWrEn = 1; maskWrData = m;
    @(negedge clk);
    maskWrEn = 0;
  endtask

  initial begin
    repeat (500000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    check("R8 reset outputs", {rspValid, reqReady, priIdx, secIdx, priOffset, secOffset}, 
          {1'b0, 1'b1, {(4*IW+14){1'b0}}});
    rstN = 1;
    @(negedge clk);
    curMask = '1;
    // R8: reset mask all ones
    doReq(24'hABCDEF, 0, 0, curMask);

    // sweep over patterns, sizes and masks (R1 R2 R3 R4)
    for (int mi = 0; mi < 3; mi++) begin
      curMask = (mi == 0) ? 10'h3FF : (mi == 1) ? 10'h0FF : 10'h2A5;
      writeMask(curMask);
      for (int i = 0; i < 200; i++) begin
        logic [VW-1:0] v;
        v = VW'(i * 83231 + mi * 7919 + (i << 17));
        doReq(v, i[0], (i % 7 == 0) ? 2 : 0, curMask);
      end
    end
    // boundary page numbers
    doReq('1, 0, 1, curMask);
    doReq('1, 1, 1, curMask);
    doReq('0, 0, 0, curMask);
    doReq(24'h010000, 0, 0, curMask);
    doReq(24'h000010, 1, 0, curMask);

    // R7: write while a result is pending is ignored
    writeMask(10'h3FF);
    curMask = 10'h3FF;
    @(negedge clk);
    reqVpn = 24'h5A5A5A; reqLarge = 0; reqValid = 1;
    @(negedge clk);
    reqValid = 0; maskWrEn = 1; maskWrData = 10'h00F;
    @(negedge clk);
    maskWrEn = 0; rspReady = 1;
    @(negedge clk);
    rspReady = 0;
    doReq(24'h123456, 0, 0, 10'h3FF);  // R7 old mask still used

    // R7: write on the acceptance edge is ignored
    @(negedge clk);
    reqVpn = 24'h777777; reqLarge = 1; reqValid = 1; maskWrEn = 1; maskWrData = 10'h003;
    @(negedge clk);
    reqValid = 0; maskWrEn = 0;
    check("R7 accept-edge write ignored", priIdx, rawLow(24'h777777, 1) & 10'h3FF);
    rspReady = 1;
    @(negedge clk);
    rspReady = 0;
    doReq(24'h0F0F0F, 1, 0, 10'h3FF);

    // R7: idle write takes effect
    writeMask(10'h00F);
    doReq(24'h123456, 0, 0, 10'h00F);
    doReq(24'hFEDCBA, 1, 0, 10'h00F);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule